// File: doc/BRIEF.md
# LIN-capable asynchronous serial transceiver

This block is one full-duplex asynchronous serial channel. It sends and receives 8-bit characters, with or without a parity bit, at a rate set by a divider inside the channel. Both directions hold one character in a holding register while another moves through the shift register. The receiver reports parity, framing and overrun errors alongside the character it delivers.

For LIN buses the channel has two roles. As master it sends a break: a long low period of 13 to 16 bit times, then a high delimiter of 1 to 4 bit times, then any character that is waiting. As slave it recognises an incoming break and raises a flag. A break is not reported as a character and is not reported as a framing error. Checksums, identifiers and scheduling are left to the logic around the block.

Top module: `lin_uart`

## Requirements
- R1: After reset, txd is high, rx_valid, tx_full, tx_busy, err_parity, err_frame, err_overrun and brk_det are all 0.
- R2: A character goes out on txd as follows. It starts with one low start bit. Eight data bits follow, least significant first. The parity bit follows when it is enabled. It ends with one high stop bit. A character sent out of txd and looped into rxd comes back on rx_data unchanged, with no error flag set.
- R3: When cfg_par_en is 1, a parity bit follows the data. With cfg_par_odd=0 the parity is even: the data bits and the parity bit hold an even number of ones. With cfg_par_odd=1 that number is odd. A received parity bit that does not match sets err_parity together with the character.
- R4: The receiver may sample a stop bit low. If the line then goes high again before 11 bit times of continuous low, the character is delivered with err_frame=1 when the line goes high. In master mode (cfg_master=1) such a character is delivered with err_frame=1 at once.
- R5: A character may complete while rx_valid=1 and rx_rd is not asserted. That character is discarded, err_overrun goes to 1, and rx_data keeps the unread character. A cycle with rx_rd=1 clears rx_valid and all four receive flags.
- R6: In master mode, a pulse on tx_brk_req drives txd low for 13+cfg_brk_len bit times.
- R7: After the break low, txd stays high for 1+cfg_dlm_len bit times. A character already in the holding register then starts on the next bit boundary.
- R8: In slave mode (cfg_master=0), tx_brk_req has no effect: txd stays high and tx_busy stays 0.
- R9: In slave mode, rxd may stay low for at least 11 bit times after a start edge. This sets brk_det. No character is delivered and err_frame stays 0.
- R10: tx_wr loads tx_data only when tx_full=0. A write while tx_full=1 is ignored, and the held character is sent unchanged.
- R11: One bit time is 16*(cfg_div+1) clock cycles. The divider makes one tick every cfg_div+1 cycles, and each bit lasts 16 ticks.
- R12: The receiver samples the start bit at half a bit time after the falling edge. A low pulse shorter than half a bit on an idle line is ignored, and no character is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Oversampling tick period minus one |
| cfg_par_en | input | 1 | Parity bit enabled |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_master | input | 1 | 1 selects master (sends breaks), 0 selects slave (detects breaks) |
| cfg_brk_len | input | 2 | Break length is 13 plus this value, in bit times |
| cfg_dlm_len | input | 2 | Delimiter length is 1 plus this value, in bit times |
| tx_wr | input | 1 | Write tx_data into the transmit holding register |
| tx_data | input | DATA_W | Character to send |
| tx_brk_req | input | 1 | Request a break (master mode only) |
| tx_full | output | 1 | Transmit holding register occupied |
| tx_busy | output | 1 | Transmit shifter active |
| txd | output | 1 | Serial output, high when idle |
| rxd | input | 1 | Serial input |
| rx_rd | input | 1 | Consume the received character and clear the flags |
| rx_data | output | DATA_W | Received character |
| rx_valid | output | 1 | Receive holding register holds an unread character |
| err_parity | output | 1 | Parity mismatch on the held character |
| err_frame | output | 1 | Stop bit of the held character was low |
| err_overrun | output | 1 | A character was discarded because the holding register was full |
| brk_det | output | 1 | A break was detected (slave mode) |

## Verification
The bench compares every delivered character and its flags against a queue of expected characters, so each fault in the receiver shows up at the ports. A receiver that loses its bit alignment or its shift order gives a wrong byte, or an extra or missing character, within one frame time. A wrong parity sense or a wrong stop-bit decision is visible on the same character. A fault in the transmit state is measured on txd as a break or delimiter length that is off by whole bit times, or as a character missing from the loopback. In both cases the error appears within the frame in which it occurs. A stuck break-detect or overrun path shows as a flag that is wrong when the bench reads it after the stimulus.

// File: rtl/lin_uart_pkg.sv
package lin_uart_pkg;
  localparam int OVS      = 16;
  localparam int OVS_W    = $clog2(OVS);
  localparam int BRK_BASE = 13;
  localparam int DLM_BASE = 1;
  localparam int BRK_MIN  = 11;
  localparam int CNT_W    = 5;

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP, TX_BRK, TX_DLM
  } tx_st_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAITHI
  } rx_st_e;
endpackage

// File: rtl/lin_uart_baud.sv
module lin_uart_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q >= div);

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lin_uart_tx.sv
module lin_uart_tx
  import lin_uart_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              master,
  input  logic [1:0]        brk_len,
  input  logic [1:0]        dlm_len,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              brk_req,
  output logic              full,
  output logic              busy,
  output logic              txd
);
  tx_st_e            st_q, st_d;
  logic [OVS_W-1:0]  sub_q, sub_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d, hold_q, hold_d;
  logic              par_q, par_d, hold_v_q, hold_v_d, pend_q, pend_d;
  logic              bit_end, accept, load;
  logic [CNT_W-1:0]  brk_last, dlm_last;

  assign bit_end  = tick && (sub_q == OVS_W'(OVS - 1));
  assign accept   = wr && !hold_v_q;
  assign brk_last = CNT_W'(BRK_BASE - 1) + CNT_W'(brk_len);
  assign dlm_last = CNT_W'(DLM_BASE - 1) + CNT_W'(dlm_len);

  always_comb begin
    st_d  = st_q;
    sub_d = tick ? sub_q + 1'b1 : sub_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    load  = 1'b0;
    pend_d = pend_q || (brk_req && master);
    case (st_q)
      TX_IDLE: begin
        sub_d = '0;
        if (tick) begin
          if (pend_q) begin
            st_d = TX_BRK; cnt_d = '0; pend_d = 1'b0;
          end else if (hold_v_q) begin
            st_d = TX_START; load = 1'b1;
          end
        end
      end
      TX_START: if (bit_end) st_d = TX_DATA;
      TX_DATA: if (bit_end) begin
        sh_d  = sh_q >> 1;
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(DATA_W - 1)) st_d = par_en ? TX_PAR : TX_STOP;
      end
      TX_PAR: if (bit_end) st_d = TX_STOP;
      TX_STOP, TX_DLM: if (bit_end) begin
        if (st_q == TX_DLM && cnt_q != dlm_last) begin
          cnt_d = cnt_q + 1'b1;
        end else if (pend_q) begin
          st_d = TX_BRK; cnt_d = '0; pend_d = 1'b0;
        end else if (hold_v_q) begin
          st_d = TX_START; load = 1'b1;
        end else begin
          st_d = TX_IDLE;
        end
      end
      TX_BRK: if (bit_end) begin
        if (cnt_q == brk_last) begin
          st_d = TX_DLM; cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = TX_IDLE;
    endcase
    par_d    = par_q;
    hold_d   = hold_q;
    hold_v_d = hold_v_q;
    if (load) begin
      sh_d     = hold_q;
      par_d    = (^hold_q) ^ par_odd;
      cnt_d    = '0;
      hold_v_d = 1'b0;
    end
    if (accept) begin
      hold_d   = wdata;
      hold_v_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= TX_IDLE; sub_q <= '0; cnt_q <= '0; sh_q <= '0;
      par_q <= 1'b0; hold_q <= '0; hold_v_q <= 1'b0; pend_q <= 1'b0;
    end else begin
      st_q <= st_d; sub_q <= sub_d; cnt_q <= cnt_d; sh_q <= sh_d;
      par_q <= par_d; hold_q <= hold_d; hold_v_q <= hold_v_d; pend_q <= pend_d;
    end
  end

  always_comb begin
    case (st_q)
      TX_START, TX_BRK: txd = 1'b0;
      TX_DATA:          txd = sh_q[0];
      TX_PAR:           txd = par_q;
      default:          txd = 1'b1;
    endcase
  end

  assign full = hold_v_q;
  assign busy = (st_q != TX_IDLE);
endmodule

// File: rtl/lin_uart_rx.sv
module lin_uart_rx
  import lin_uart_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              master,
  input  logic              rd,
  output logic [DATA_W-1:0] data,
  output logic              valid,
  output logic              perr,
  output logic              ferr,
  output logic              ovr,
  output logic              brk
);
  localparam int BRK_TICKS = BRK_MIN * OVS;
  localparam int LOW_W     = $clog2(BRK_TICKS + 1);
  localparam logic [OVS_W-1:0] HALF = OVS_W'(OVS / 2 - 1);
  localparam logic [OVS_W-1:0] LAST = OVS_W'(OVS - 1);

  rx_st_e            st_q, st_d;
  logic [OVS_W-1:0]  sub_q, sub_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d, data_q, data_d;
  logic [LOW_W-1:0]  low_q, low_d;
  logic              s1_q, s2_q, s3_q, rx_s, fall;
  logic              pe_q, pe_d, pend_q, pend_d;
  logic              valid_q, valid_d, perr_q, perr_d, ferr_q, ferr_d;
  logic              ovr_q, ovr_d, brk_q, brk_d;
  logic              dlv, dlv_fe, brk_ev, smp;

  assign rx_s   = s2_q;
  assign fall   = s3_q && !s2_q;
  assign smp    = tick && (sub_q == LAST);
  assign brk_ev = (st_q == RX_WAITHI) && pend_q && !master &&
                  (low_q >= LOW_W'(BRK_TICKS));

  always_comb begin
    st_d = st_q; sub_d = tick ? sub_q + 1'b1 : sub_q; cnt_d = cnt_q;
    sh_d = sh_q; pe_d = pe_q; pend_d = pend_q;
    dlv = 1'b0; dlv_fe = 1'b0;
    if (rx_s) low_d = '0;
    else if (tick && low_q != LOW_W'(BRK_TICKS)) low_d = low_q + 1'b1;
    else low_d = low_q;
    case (st_q)
      RX_IDLE: begin
        sub_d = '0;
        if (fall) st_d = RX_START;
      end
      RX_START: if (tick && sub_q == HALF) begin
        if (rx_s) st_d = RX_IDLE;
        else begin
          st_d = RX_DATA; sub_d = '0; cnt_d = '0; pe_d = 1'b0;
        end
      end
      RX_DATA: if (smp) begin
        sh_d  = {rx_s, sh_q[DATA_W-1:1]};
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(DATA_W - 1)) st_d = par_en ? RX_PAR : RX_STOP;
      end
      RX_PAR: if (smp) begin
        pe_d = rx_s ^ (^sh_q) ^ par_odd;
        st_d = RX_STOP;
      end
      RX_STOP: if (smp) begin
        if (rx_s) begin
          dlv = 1'b1; st_d = RX_IDLE;
        end else if (master) begin
          dlv = 1'b1; dlv_fe = 1'b1; st_d = RX_WAITHI;
        end else begin
          pend_d = 1'b1; st_d = RX_WAITHI;
        end
      end
      RX_WAITHI: begin
        if (brk_ev) pend_d = 1'b0;
        else if (rx_s) begin
          st_d = RX_IDLE; pend_d = 1'b0;
          if (pend_q) begin dlv = 1'b1; dlv_fe = 1'b1; end
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_comb begin
    data_d = data_q; valid_d = valid_q; perr_d = perr_q;
    ferr_d = ferr_q; ovr_d = ovr_q; brk_d = brk_q;
    if (rd) begin
      valid_d = 1'b0; perr_d = 1'b0; ferr_d = 1'b0; ovr_d = 1'b0; brk_d = 1'b0;
    end
    if (dlv) begin
      if (valid_q && !rd) ovr_d = 1'b1;
      else begin
        data_d = sh_q; valid_d = 1'b1; perr_d = pe_q; ferr_d = dlv_fe;
      end
    end
    if (brk_ev) brk_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1; s2_q <= 1'b1; s3_q <= 1'b1;
      st_q <= RX_IDLE; sub_q <= '0; cnt_q <= '0; sh_q <= '0; low_q <= '0;
      pe_q <= 1'b0; pend_q <= 1'b0;
      data_q <= '0; valid_q <= 1'b0; perr_q <= 1'b0; ferr_q <= 1'b0;
      ovr_q <= 1'b0; brk_q <= 1'b0;
    end else begin
      s1_q <= rxd; s2_q <= s1_q; s3_q <= s2_q;
      st_q <= st_d; sub_q <= sub_d; cnt_q <= cnt_d; sh_q <= sh_d; low_q <= low_d;
      pe_q <= pe_d; pend_q <= pend_d;
      data_q <= data_d; valid_q <= valid_d; perr_q <= perr_d; ferr_q <= ferr_d;
      ovr_q <= ovr_d; brk_q <= brk_d;
    end
  end

  assign data  = data_q;
  assign valid = valid_q;
  assign perr  = perr_q;
  assign ferr  = ferr_q;
  assign ovr   = ovr_q;
  assign brk   = brk_q;
endmodule

// File: rtl/lin_uart.sv
module lin_uart #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_master,
  input  logic [1:0]        cfg_brk_len,
  input  logic [1:0]        cfg_dlm_len,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_brk_req,
  output logic              tx_full,
  output logic              tx_busy,
  output logic              txd,
  input  logic              rxd,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              brk_det
);
  logic rst_m_q, rst_s_q, tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0; rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1; rst_s_q <= rst_m_q;
    end
  end

  lin_uart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_s_q), .div(cfg_div), .tick(tick)
  );

  lin_uart_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_s_q), .tick(tick),
    .par_en(cfg_par_en), .par_odd(cfg_par_odd), .master(cfg_master),
    .brk_len(cfg_brk_len), .dlm_len(cfg_dlm_len),
    .wr(tx_wr), .wdata(tx_data), .brk_req(tx_brk_req),
    .full(tx_full), .busy(tx_busy), .txd(txd)
  );

  lin_uart_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_s_q), .tick(tick), .rxd(rxd),
    .par_en(cfg_par_en), .par_odd(cfg_par_odd), .master(cfg_master),
    .rd(rx_rd), .data(rx_data), .valid(rx_valid),
    .perr(err_parity), .ferr(err_frame), .ovr(err_overrun), .brk(brk_det)
  );
endmodule

// File: rtl/lin_uart_chk.sv
module lin_uart_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_master,
  input logic              tx_wr,
  input logic              tx_full,
  input logic              tx_busy,
  input logic              rx_rd,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              err_parity,
  input logic              err_frame,
  input logic              err_overrun,
  input logic              brk_det
);
  AST_TX_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && !tx_full) |=> (tx_full || tx_busy)); // R10
  AST_RX_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_rd) |=> (rx_valid && $stable(rx_data))); // R5
  AST_READ_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd |=> !err_overrun); // R5
  AST_OVR_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    err_overrun |-> rx_valid); // R5
  AST_PERR_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    err_parity |-> rx_valid); // R3
  AST_FERR_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    err_frame |-> rx_valid); // R4
  AST_BRK_SLAVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_det) |-> (!cfg_master && !$rose(rx_valid))); // R9
endmodule

bind lin_uart lin_uart_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master),
  .tx_wr(tx_wr), .tx_full(tx_full), .tx_busy(tx_busy),
  .rx_rd(rx_rd), .rx_data(rx_data), .rx_valid(rx_valid),
  .err_parity(err_parity), .err_frame(err_frame),
  .err_overrun(err_overrun), .brk_det(brk_det)
);

// File: tb/tb_lin_uart.sv
`timescale 1ns/1ps
module tb_lin_uart;
  logic        clk, rst_n;
  logic [15:0] cfg_div;
  logic        cfg_par_en, cfg_par_odd, cfg_master;
  logic [1:0]  cfg_brk_len, cfg_dlm_len;
  logic        tx_wr, tx_brk_req, rd_mon, rd_tb, rx_rd;
  logic [7:0]  tx_data, rx_data;
  logic        tx_full, tx_busy, txd, rxd, tb_rxd, lb_en, mon_en;
  logic        rx_valid, err_parity, err_frame, err_overrun, brk_det;

  int n_chk = 0, n_fail = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];

  assign rx_rd = rd_mon | rd_tb;
  assign rxd   = lb_en ? txd : tb_rxd;

  lin_uart dut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_master(cfg_master),
    .cfg_brk_len(cfg_brk_len), .cfg_dlm_len(cfg_dlm_len),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_brk_req(tx_brk_req),
    .tx_full(tx_full), .tx_busy(tx_busy), .txd(txd), .rxd(rxd),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_valid(rx_valid),
    .err_parity(err_parity), .err_frame(err_frame),
    .err_overrun(err_overrun), .brk_det(brk_det)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  // monitor: pops the scoreboard whenever a character is delivered
  initial begin
    rd_mon = 1'b0;
    forever begin
      @(negedge clk);
      if (rd_mon) rd_mon = 1'b0;
      else if (mon_en && rx_valid) begin
        if (exp_q.size() == 0) begin
          chk("R12 unexpected character", {err_frame, err_parity, rx_data}, 10'h3ff);
        end else begin
          logic [9:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, {err_frame, err_parity, rx_data}, e);
        end
        rd_mon = 1'b1;
      end
    end
  end

  function automatic int bitc();
    return 16 * (int'(cfg_div) + 1);
  endfunction

  task automatic expect_rx(input logic [7:0] d, input logic pe, input logic fe, input string t);
    exp_q.push_back({fe, pe, d});
    tag_q.push_back(t);
  endtask

  task automatic tx_send(input logic [7:0] d);
    @(negedge clk);
    while (tx_full) @(negedge clk);
    tx_wr = 1'b1; tx_data = d;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (tx_busy || tx_full) @(negedge clk);
    repeat (3 * bitc()) @(negedge clk);
  endtask

  task automatic drive_frame(input logic [7:0] d, input bit bad_par,
                             input logic stop_v, input int extra);
    @(negedge clk);
    tb_rxd = 1'b0; repeat (bitc()) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      tb_rxd = d[i]; repeat (bitc()) @(negedge clk);
    end
    if (cfg_par_en) begin
      tb_rxd = (^d) ^ cfg_par_odd ^ bad_par; repeat (bitc()) @(negedge clk);
    end
    tb_rxd = stop_v; repeat (bitc() * (1 + extra)) @(negedge clk);
    tb_rxd = 1'b1; repeat (3 * bitc()) @(negedge clk);
  endtask

  task automatic pulse_read();
    @(negedge clk); rd_tb = 1'b1; @(negedge clk); rd_tb = 1'b0;
  endtask

  task automatic measure_break(input int bl, input int dl, input string t);
    int lo, hi;
    cfg_master = 1'b1; cfg_brk_len = 2'(bl); cfg_dlm_len = 2'(dl);
    @(negedge clk);
    tx_brk_req = 1'b1; tx_wr = 1'b1; tx_data = 8'h3c;
    @(negedge clk);
    tx_brk_req = 1'b0; tx_wr = 1'b0;
    @(negedge txd);
    @(negedge clk);
    lo = 0;
    while (txd === 1'b0) begin lo++; @(negedge clk); end
    hi = 0;
    while (txd === 1'b1) begin hi++; @(negedge clk); end
    chk({t, " R6 break low cycles"}, lo, (13 + bl) * bitc());
    chk({t, " R7 delimiter high cycles"}, hi, (1 + dl) * bitc());
    drain();
  endtask

  initial begin
    rst_n = 1'b0; cfg_div = 16'd1; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    cfg_master = 1'b0; cfg_brk_len = 2'd0; cfg_dlm_len = 2'd0;
    tx_wr = 1'b0; tx_data = 8'h00; tx_brk_req = 1'b0; rd_tb = 1'b0;
    tb_rxd = 1'b1; lb_en = 1'b1; mon_en = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 txd", txd, 1);
    chk("R1 flags", {rx_valid, tx_full, tx_busy, err_parity, err_frame,
                     err_overrun, brk_det}, 0);

    // R2 loopback without parity
    foreach (exp_q[i]) ;
    begin
      logic [7:0] pat [4] = '{8'h55, 8'ha3, 8'h00, 8'hff};
      for (int i = 0; i < 4; i++) begin
        expect_rx(pat[i], 1'b0, 1'b0, "R2 loopback");
        tx_send(pat[i]);
      end
    end
    drain();
    chk("R2 all characters received", exp_q.size(), 0);

    // R3 loopback with even then odd parity
    cfg_par_en = 1'b1;
    for (int p = 0; p < 2; p++) begin
      cfg_par_odd = p[0];
      expect_rx(8'h81, 1'b0, 1'b0, "R3 parity loopback");
      tx_send(8'h81);
      expect_rx(8'h7e, 1'b0, 1'b0, "R3 parity loopback");
      tx_send(8'h7e);
      drain();
    end

    // R10 write into a full holding register is ignored
    cfg_par_en = 1'b0;
    expect_rx(8'h11, 1'b0, 1'b0, "R10 first");
    expect_rx(8'h22, 1'b0, 1'b0, "R10 second");
    tx_send(8'h11);
    tx_send(8'h22);
    @(negedge clk);
    chk("R10 holding register full", tx_full, 1);
    tx_wr = 1'b1; tx_data = 8'h99; @(negedge clk); tx_wr = 1'b0;
    drain();
    chk("R10 ignored write not sent", exp_q.size(), 0);

    // bench-driven frames on rxd
    lb_en = 1'b0;
    cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    expect_rx(8'h5a, 1'b1, 1'b0, "R3 bad even parity");
    drive_frame(8'h5a, 1'b1, 1'b1, 0);
    cfg_par_odd = 1'b1;
    expect_rx(8'h3c, 1'b1, 1'b0, "R3 bad odd parity");
    drive_frame(8'h3c, 1'b1, 1'b1, 0);
    cfg_par_en = 1'b0;

    // R4 framing error, slave mode, line returns high early
    expect_rx(8'h5a, 1'b0, 1'b1, "R4 low stop bit");
    drive_frame(8'h5a, 1'b0, 1'b0, 1);
    // R4 master mode: delivered at once
    cfg_master = 1'b1;
    expect_rx(8'h24, 1'b0, 1'b1, "R4 low stop bit master");
    drive_frame(8'h24, 1'b0, 1'b0, 0);
    cfg_master = 1'b0;
    chk("R4 scoreboard drained", exp_q.size(), 0);

    // R12 short glitch ignored
    @(negedge clk); tb_rxd = 1'b0; repeat (4) @(negedge clk); tb_rxd = 1'b1;
    repeat (2 * bitc()) @(negedge clk);
    chk("R12 glitch no character", rx_valid, 0);

    // R9 slave break detection
    mon_en = 1'b0;
    @(negedge clk); tb_rxd = 1'b0; repeat (13 * bitc()) @(negedge clk);
    tb_rxd = 1'b1; repeat (2 * bitc()) @(negedge clk);
    chk("R9 break flag", brk_det, 1);
    chk("R9 no character, no framing error", {rx_valid, err_frame}, 0);
    pulse_read();
    @(negedge clk);
    chk("R5 read clears break flag", brk_det, 0);

    // R5 overrun
    lb_en = 1'b1;
    tx_send(8'h11);
    tx_send(8'h22);
    drain();
    chk("R5 first kept", {rx_valid, rx_data}, {1'b1, 8'h11});
    chk("R5 overrun flag", err_overrun, 1);
    pulse_read();
    @(negedge clk);
    chk("R5 read clears", {rx_valid, err_overrun}, 0);
    mon_en = 1'b1;

    // R8 break request ignored in slave mode
    lb_en = 1'b0;
    begin
      int lows = 0;
      @(negedge clk); tx_brk_req = 1'b1; @(negedge clk); tx_brk_req = 1'b0;
      for (int i = 0; i < 4 * bitc(); i++) begin
        if (!txd || tx_busy) lows++;
        @(negedge clk);
      end
      chk("R8 slave break ignored", lows, 0);
    end

    // R6 R7 break and delimiter lengths
    for (int b = 0; b < 4; b++) measure_break(b, 3 - b, "len sweep");

    // R11 other divider
    cfg_div = 16'd3;
    repeat (10) @(negedge clk);
    measure_break(0, 0, "R11 divider 3");
    cfg_master = 1'b0;
    lb_en = 1'b1;
    expect_rx(8'hc6, 1'b0, 1'b0, "R11 loopback divider 3");
    tx_send(8'hc6);
    drain();
    chk("R11 character received", exp_q.size(), 0);

    finish_run();
  end
endmodule